// File: doc/BRIEF.md
# Selectable Multi-Group Event Counter

This block is a statistics unit that counts how often one chosen event occurs. Events arrive as single-cycle pulses, spread over five groups. Group 0 and group 4 carry one pulse vector per lane; groups 1, 2 and 3 are lane-independent. Software picks the event through a control register, which holds a group, an event and a lane. It starts and stops counting by writing a command code into that register, and reads the running total from a data register.

A counter is restarted with two writes: first a stop command, then a start command. The start clears the total. A start written while the counter is already running does not clear it. The register port is plain control: there is a write strobe, an address and write data. Read data is a combinational view of the registered state at the addressed offset, so no handshake or back-pressure applies.

Top module: `evt_stat_counter`

## Requirements
- R1: After reset, the control register reads 0: counting is off, lane 0, group 0 and event 0 are selected. The data register also reads 0.
- R2: The control register is at offset 0x08 and the data register at offset 0x0C. Any other offset reads 0. Writes to 0x0C have no effect on the count.
- R3: Control field positions are: group in bits [27:24], event in bits [23:16] and lane in bits [11:8]. These fields read back as written. All other bits read 0, including the command field.
- R4: The command field is bits [4:2]. Code 3 starts counting and code 1 stops it. Any other code leaves the running state unchanged. Bit 7 reads 1 while counting and 0 while stopped.
- R5: A start command issued while stopped clears the count to 0. A start command issued while already counting keeps the count.
- R6: While counting, each clock edge with the selected pulse high adds exactly one. While stopped, the count holds.
- R7: For group 0 and group 4, only the pulse of the lane named by the lane field is counted. Groups 1, 2 and 3 ignore the lane field.
- R8: Only these selections count anything:
  - group 0: events 0–10
  - group 1: events 5–10, 12 and 13
  - group 2: events 0–7
  - group 3: events 0–5
  - group 4: events 0–1

  Any other group or event, or a lane at or above NUM_LANES for a per-lane group, counts nothing.
- R9: The count saturates at the all-ones value of CNT_W bits (0xFFFFFFFF at the default width) instead of wrapping. It reads zero-extended to 32 bits.
- R10: A register write takes effect at the clock edge that samples it. A pulse on that same edge is judged by the settings that applied before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| lane_evt_g0 | input | NUM_LANES*11 | Group 0 pulses, lane l event e at bit l*11+e |
| evt_g1 | input | 14 | Group 1 pulses, event e at bit e |
| evt_g2 | input | 8 | Group 2 pulses, event e at bit e |
| evt_g3 | input | 6 | Group 3 pulses, event e at bit e |
| lane_evt_g4 | input | NUM_LANES*2 | Group 4 pulses, lane l event e at bit l*2+e |

## Verification
A table of selections is walked through every group. Each selection receives three pulses, and each pulse lands on one chosen input bit: sometimes the selected one, sometimes the right event on a different lane, sometimes a neighbouring unlisted event. A count of 3 against 0 separates correct multiplexing from off-by-lane, off-by-event and gap-decoding faults.

Directed sequences cover the remaining behaviour:
- a start without a prior stop, and pulses while stopped, which tell restart clearing apart from stopping;
- a pulse on the very edge of a start or stop write, which exposes which settings the design applies on that edge;
- a long burst against a narrow counter, which separates saturation from wrap-around.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  localparam int GRP_LSB  = 24;
  localparam int GRP_W    = 4;
  localparam int EVT_LSB  = 16;
  localparam int EVT_W    = 8;
  localparam int LANE_LSB = 8;
  localparam int LANE_W   = 4;
  localparam int STAT_BIT = 7;
  localparam int CMD_LSB  = 2;
  localparam int CMD_W    = 3;

  localparam logic [CMD_W-1:0] CMD_START = 3'd3;
  localparam logic [CMD_W-1:0] CMD_STOP  = 3'd1;

  localparam int G0_N = 11;
  localparam int G1_N = 14;
  localparam int G2_N = 8;
  localparam int G3_N = 6;
  localparam int G4_N = 2;

  localparam logic [7:0] CTRL_OFS = 8'h08;
  localparam logic [7:0] DATA_OFS = 8'h0C;
endpackage

// File: rtl/evt_cnt_ctrl.sv
module evt_cnt_ctrl
  import evt_cnt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [GRP_W-1:0]  grp,
  output logic [EVT_W-1:0]  evt,
  output logic [LANE_W-1:0] lane,
  output logic              en,
  output logic              clr
);
  logic             wr_ctl;
  logic [CMD_W-1:0] cmd;
  logic             cmd_start;
  logic             cmd_stop;

  assign wr_ctl    = wr && (addr == ADDR_W'(CTRL_OFS));
  assign cmd       = wdata[CMD_LSB +: CMD_W];
  assign cmd_start = wr_ctl && (cmd == CMD_START);
  assign cmd_stop  = wr_ctl && (cmd == CMD_STOP);
  assign clr       = cmd_start && !en;

  wire unused_wbits = ^{wdata[31:28], wdata[15:12], wdata[7:5], wdata[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp  <= '0;
      evt  <= '0;
      lane <= '0;
      en   <= 1'b0;
    end else if (wr_ctl) begin
      grp  <= wdata[GRP_LSB +: GRP_W];
      evt  <= wdata[EVT_LSB +: EVT_W];
      lane <= wdata[LANE_LSB +: LANE_W];
      if (cmd_start)     en <= 1'b1;
      else if (cmd_stop) en <= 1'b0;
    end
  end

  // R4: start and stop codes set the running state on the next edge
  p_cmd_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> en);
  p_cmd_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> !en);
  // R4: writes elsewhere never change the running state
  p_state_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_start && !cmd_stop) |=> $stable(en));
  // R3: the lane field loads from the written data
  p_lane_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (lane == $past(wdata[LANE_LSB +: LANE_W])));
endmodule

// File: rtl/evt_cnt_sel.sv
module evt_cnt_sel
  import evt_cnt_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic [GRP_W-1:0]          grp,
  input  logic [EVT_W-1:0]          evt,
  input  logic [LANE_W-1:0]         lane,
  input  logic [NUM_LANES*G0_N-1:0] g0,
  input  logic [G1_N-1:0]           g1,
  input  logic [G2_N-1:0]           g2,
  input  logic [G3_N-1:0]           g3,
  input  logic [NUM_LANES*G4_N-1:0] g4,
  output logic                      hit
);
  localparam int LIDX_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

  logic [G0_N-1:0] g0_l [NUM_LANES];
  logic [G4_N-1:0] g4_l [NUM_LANES];

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign g0_l[l] = g0[l*G0_N +: G0_N];
    assign g4_l[l] = g4[l*G4_N +: G4_N];
  end

  logic              lane_ok;
  logic [LIDX_W-1:0] lidx;

  assign lane_ok = (32'(lane) < NUM_LANES);
  assign lidx    = LIDX_W'(lane);

  always_comb begin
    hit = 1'b0;
    case (grp)
      4'd0: if (lane_ok && (evt < 8'(G0_N))) hit = g0_l[lidx][evt[3:0]];
      4'd1: if ((evt >= 8'd5 && evt <= 8'd10) || evt == 8'd12 || evt == 8'd13)
              hit = g1[evt[3:0]];
      4'd2: if (evt < 8'(G2_N)) hit = g2[evt[2:0]];
      4'd3: if (evt < 8'(G3_N)) hit = g3[evt[2:0]];
      4'd4: if (lane_ok && (evt < 8'(G4_N))) hit = g4_l[lidx][evt[0]];
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/evt_cnt_core.sv
module evt_cnt_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             hit,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                cnt <= '0;
    else if (clr)                              cnt <= '0;
    else if (en && hit && (cnt != CNT_MAX))    cnt <= cnt + 1'b1;
  end

  // R5: a restart leaves zero behind
  p_restart_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
  // R6: stopped counter holds
  p_frozen_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(cnt));
  // R6: at most one step per edge
  p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> ($stable(cnt) || (cnt == $past(cnt) + 1'b1)));
  // R9: the top value sticks
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt == CNT_MAX) && !clr) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/evt_stat_counter.sv
module evt_stat_counter
  import evt_cnt_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  input  logic [NUM_LANES*G0_N-1:0] lane_evt_g0,
  input  logic [G1_N-1:0]           evt_g1,
  input  logic [G2_N-1:0]           evt_g2,
  input  logic [G3_N-1:0]           evt_g3,
  input  logic [NUM_LANES*G4_N-1:0] lane_evt_g4
);
  logic [GRP_W-1:0]  grp;
  logic [EVT_W-1:0]  evt;
  logic [LANE_W-1:0] lane;
  logic              en;
  logic              clr;
  logic              hit;
  logic [CNT_W-1:0]  cnt;

  evt_cnt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .grp(grp), .evt(evt), .lane(lane), .en(en), .clr(clr)
  );

  evt_cnt_sel #(.NUM_LANES(NUM_LANES)) u_sel (
    .grp(grp), .evt(evt), .lane(lane),
    .g0(lane_evt_g0), .g1(evt_g1), .g2(evt_g2), .g3(evt_g3), .g4(lane_evt_g4),
    .hit(hit)
  );

  evt_cnt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .hit(hit), .cnt(cnt)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(CTRL_OFS)) begin
      reg_rdata[GRP_LSB +: GRP_W]   = grp;
      reg_rdata[EVT_LSB +: EVT_W]   = evt;
      reg_rdata[LANE_LSB +: LANE_W] = lane;
      reg_rdata[STAT_BIT]           = en;
    end else if (reg_addr == ADDR_W'(DATA_OFS)) begin
      reg_rdata = 32'(cnt);
    end
  end

  // R8: an undefined group never produces a count pulse
  p_bad_group_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (grp > 4'd4) |-> !hit);
  // R8: an out-of-range lane silences per-lane groups
  p_bad_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (((grp == 4'd0) || (grp == 4'd4)) && (32'(lane) >= NUM_LANES)) |-> !hit);
endmodule

// File: tb/evt_stat_counter_test.sv
module evt_stat_counter_test;
  localparam int NL = 4;
  localparam int CW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NL*11-1:0] g0 = '0;
  logic [13:0] g1 = '0;
  logic [7:0]  g2 = '0;
  logic [5:0]  g3 = '0;
  logic [NL*2-1:0] g4 = '0;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  evt_stat_counter #(.ADDR_W(8), .NUM_LANES(NL), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lane_evt_g0(g0), .evt_g1(g1), .evt_g2(g2), .evt_g3(g3), .lane_evt_g4(g4)
  );

  // fields: grp(4) evt(8) lane(4) pulse group(4) pulse bit(8) expected(4)
  localparam logic [31:0] TBL [13] = '{
    {4'd0, 8'd3,  4'd0, 4'd0, 8'd3,  4'd3},
    {4'd0, 8'd3,  4'd2, 4'd0, 8'd25, 4'd3},
    {4'd0, 8'd3,  4'd2, 4'd0, 8'd3,  4'd0},
    {4'd1, 8'd6,  4'd3, 4'd1, 8'd6,  4'd3},
    {4'd1, 8'd11, 4'd0, 4'd1, 8'd11, 4'd0},
    {4'd1, 8'd4,  4'd0, 4'd1, 8'd4,  4'd0},
    {4'd2, 8'd7,  4'd0, 4'd2, 8'd7,  4'd3},
    {4'd2, 8'd8,  4'd0, 4'd2, 8'd0,  4'd0},
    {4'd3, 8'd5,  4'd1, 4'd3, 8'd5,  4'd3},
    {4'd4, 8'd1,  4'd1, 4'd4, 8'd3,  4'd3},
    {4'd4, 8'd2,  4'd0, 4'd4, 8'd2,  4'd0},
    {4'd0, 8'd0,  4'd5, 4'd0, 8'd0,  4'd0},
    {4'd5, 8'd0,  4'd0, 4'd0, 8'd0,  4'd0}
  };

  function automatic logic [31:0] ctl(input int g, input int e, input int l, input int c);
    return {4'd0, 4'(g), 8'(e), 4'd0, 4'(l), 3'd0, 3'(c), 2'd0};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic set_bit(input int g, input int idx, input logic v);
    case (g)
      0: g0[idx] = v;
      1: g1[idx] = v;
      2: g2[idx] = v;
      3: g3[idx] = v;
      default: g4[idx] = v;
    endcase
  endtask

  task automatic pulse(input int g, input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); set_bit(g, idx, 1'b1);
      @(negedge clk); set_bit(g, idx, 1'b0);
    end
  endtask

  task automatic restart(input int g, input int e, input int l);
    wr(8'h08, ctl(g, e, l, 1));
    wr(8'h08, ctl(g, e, l, 3));
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(8'h08, v); check("R1 ctrl", v, 32'h0);
    rd(8'h0C, v); check("R1 data", v, 32'h0);

    // R6 R7 R8: table walk
    for (int i = 0; i < 13; i++) begin
      restart(int'(TBL[i][31:28]), int'(TBL[i][27:20]), int'(TBL[i][19:16]));
      pulse(int'(TBL[i][15:12]), int'(TBL[i][11:4]), 3);
      rd(8'h0C, v);
      check($sformatf("R6 R7 R8 row %0d", i), v, 32'(TBL[i][3:0]));
    end

    // R3: field readback, other bits zero; code 7 leaves counting off
    wr(8'h08, 32'h0000_0004);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v); check("R3 readback", v, 32'h0FFF_0F00);

    // R4: start, other codes, stop
    wr(8'h08, ctl(2, 1, 0, 3));
    rd(8'h08, v); check("R4 start status", v, 32'h0201_0080);
    wr(8'h08, ctl(2, 1, 0, 0));
    wr(8'h08, ctl(2, 1, 0, 5));
    rd(8'h08, v); check("R4 other codes keep", v, 32'h0201_0080);
    pulse(2, 1, 2);
    wr(8'h08, ctl(2, 1, 0, 1));
    rd(8'h08, v); check("R4 stop status", v, 32'h0201_0000);

    // R6: stopped counter holds
    pulse(2, 1, 3);
    rd(8'h0C, v); check("R6 hold while stopped", v, 32'd2);

    // R2: map and data write ignored
    wr(8'h0C, 32'h0000_0055);
    rd(8'h0C, v); check("R2 data write ignored", v, 32'd2);
    rd(8'h00, v); check("R2 offset 0", v, 32'h0);
    rd(8'h04, v); check("R2 offset 4", v, 32'h0);

    // R5: start clears from stop, start while running keeps
    wr(8'h08, ctl(2, 1, 0, 3));
    rd(8'h0C, v); check("R5 clear on restart", v, 32'd0);
    pulse(2, 1, 2);
    wr(8'h08, ctl(2, 1, 0, 3));
    rd(8'h0C, v); check("R5 keep when running", v, 32'd2);

    // R10: pulse on the start edge not counted, on the stop edge counted
    wr(8'h08, ctl(3, 0, 0, 1));
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h08; reg_wdata = ctl(3, 0, 0, 3); g3[0] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; g3[0] = 1'b0;
    rd(8'h0C, v); check("R10 start edge", v, 32'd0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h08; reg_wdata = ctl(3, 0, 0, 1); g3[0] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; g3[0] = 1'b0;
    rd(8'h0C, v); check("R10 stop edge", v, 32'd1);

    // R9: saturation at all ones of the counter width
    restart(2, 0, 0);
    pulse(2, 0, 20);
    rd(8'h0C, v); check("R9 saturate", v, 32'h0000_000F);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule